// File: doc/BRIEF.md
# Parallel ATA Programmed-I/O Cycle Sequencer

This block turns one host request into one complete programmed-I/O access on a parallel ATA cable. A request names a device register through a 5-bit select code. It also carries a direction, a width class (8-bit task-file register or 16-bit data port) and, for a write, the word to put on the bus. The sequencer drives the register address onto the cable with both strobes idle, then pulls the read or the write strobe low. It lets the drive stretch that strobe through its ready line and then observes a recovery gap before it takes the next request.

All timings are clock counts supplied by the host. There is one setup count, and there are separate active, recovery and cycle counts for register accesses and for data-port accesses. A 3-bit PIO mode picks how long written data stays on the bus after the write strobe rises. Read data is returned on `rdata` together with a one-clock `done` pulse. A drive that never signals ready ends the strobe at a fixed cap and raises a sticky timeout flag.

Top module: `pio_cycle_engine`

## Requirements
- R1: After reset both strobes and both chip selects are high, the data output enable is low, `req_ready` is high, and `done` and `rdy_timeout` are low.
- R2: While a cycle is in progress, the select code drives the cable as follows: `ata_addr` = bits 4:2, `ata_cs_ctl_n` = bit 1 and `ata_cs_cmd_n` = bit 0. Command-block registers use the code (reg<<2)|2, and the control/alternate-status register uses (6<<2)|1. When idle, both selects are high.
- R3: After a request is accepted, the address is presented with both strobes high for max(`t_setup`,1) clocks.
- R4: A read pulls only `ata_rd_n` low and a write pulls only `ata_wr_n` low. With ready checking off, the strobe stays low for max(t_act,1) clocks.
- R5: `req_wide`=1 selects the data-port active/recovery/cycle counts, and `req_wide`=0 selects the register counts.
- R6: With `cfg_rdy_en`=1, the strobe stays low for at least RDY_SAMPLE clocks and for at least t_act clocks. It ends at the first such clock where the synchronised ready line is high. A change on `ata_rdy` reaches that decision RDY_SYNC clocks later.
- R7: With ready checking on and the ready line held low, the strobe ends after RDY_CAP clocks. `rdy_timeout` then goes high and stays high until reset.
- R8: After the strobe rises, the recovery gap lasts max(t_cyc − strobe clocks (0 if negative), t_rec, hold clocks for a write, 1) clocks, and then `done` pulses.
- R9: Read data is the value on `ata_dd_in` at the clock edge where `ata_rd_n` rises, and it is presented on `rdata` while `done` is high.
- R10: On a write, `ata_dd_out` carries the request word with `ata_dd_oe` high while `ata_wr_n` is low. The enable stays high for the hold count after `ata_wr_n` rises: 3 clocks for mode 0, 2 for modes 1–2, and 1 for modes 3–7.
- R11: `req_ready` is high only when no cycle is in progress. `done` lasts exactly one clock and coincides with `req_ready` returning high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken on this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit data port timing, 0 = 8-bit register timing |
| req_sel | input | 5 | Register select code {A2..A0, CS1 level, CS0 level} |
| req_wdata | input | DW | Write word |
| cfg_rdy_en | input | 1 | Enable drive-ready stretching |
| cfg_pio_mode | input | 3 | PIO mode, sets the write hold count |
| t_setup | input | TW | Address setup clocks |
| t_act_reg | input | TW | Register strobe clocks |
| t_rec_reg | input | TW | Register minimum recovery clocks |
| t_cyc_reg | input | TW | Register minimum cycle clocks |
| t_act_dat | input | TW | Data strobe clocks |
| t_rec_dat | input | TW | Data minimum recovery clocks |
| t_cyc_dat | input | TW | Data minimum cycle clocks |
| ata_cs_cmd_n | output | 1 | Command-block chip select, low active |
| ata_cs_ctl_n | output | 1 | Control-block chip select, low active |
| ata_addr | output | 3 | Register address |
| ata_rd_n | output | 1 | Read strobe, low active |
| ata_wr_n | output | 1 | Write strobe, low active |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_out | output | DW | Data bus outgoing value |
| ata_dd_in | input | DW | Data bus incoming value |
| ata_rdy | input | 1 | Drive ready line |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read word |
| rdy_timeout | output | 1 | Sticky ready timeout flag |

## Verification
The bench runs register reads and writes and data-port reads and writes with differing timing sets. Measured strobe widths therefore show which count set was chosen, and measured recovery gaps show whether the cycle residue, the recovery minimum or the write hold won. Zero timing counts probe the one-clock floors. Four ready patterns are used: checking off, ready high throughout, ready rising part-way, and ready stuck low. These separate the fixed sample floor, the synchroniser latency and the cap with its sticky flag. The bench changes the bus value just after the read strobe rises, which separates capture at the rising edge from a later capture. Three PIO modes tell the three hold counts apart.

// File: rtl/pio_pkg.sv
package pio_pkg;

   localparam int SEL_W = 5;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_SETUP   = 2'd1,
      PH_STROBE  = 2'd2,
      PH_RECOVER = 2'd3
   } pio_phase_e;

   // write data hold after the write strobe rises, per PIO mode
   function automatic logic [1:0] hold_clocks(input logic [2:0] mode);
      logic [1:0] h;
      case (mode)
         3'd0:       h = 2'd3;
         3'd1, 3'd2: h = 2'd2;
         default:    h = 2'd1;
      endcase
      return h;
   endfunction

endpackage

// File: rtl/pio_rdy_sync.sv
module pio_rdy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_in,
   output logic rdy_out
);
   logic pipe [0:STAGES];

   assign pipe[0] = rdy_in;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g+1] <= 1'b0;
            else        pipe[g+1] <= pipe[g];
         end
      end
   endgenerate

   assign rdy_out = pipe[STAGES];
endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
   import pio_pkg::*;
#(
   parameter int TW         = 8,
   parameter int RDY_SAMPLE = 7,
   parameter int RDY_CAP    = 257,
   parameter int CW         = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_write,
   input  logic          start_rdy_en,
   input  logic [1:0]    start_hold,
   input  logic [TW-1:0] start_setup,
   input  logic [TW-1:0] start_act,
   input  logic [TW-1:0] start_rec,
   input  logic [TW-1:0] start_cyc,
   input  logic          rdy_s,
   output pio_phase_e    phase,
   output logic [CW-1:0] cnt,
   output logic [1:0]    hold_q,
   output logic          strobe_end,
   output logic          done,
   output logic          timeout
);
   logic [TW-1:0] setup_q, act_q, rec_q, cyc_q;
   logic          wr_q, ren_q;
   logic [CW-1:0] rec_len;
   logic [CW-1:0] resid, rec_need;
   logic          act_ok, smp_ok, cap_hit, rdy_seen, strobe_over;

   always_comb begin
      act_ok   = cnt >= CW'(act_q);
      smp_ok   = cnt >= CW'(RDY_SAMPLE);
      cap_hit  = cnt >= CW'(RDY_CAP);
      rdy_seen = act_ok && smp_ok && rdy_s;
      strobe_over = ren_q ? (rdy_seen || cap_hit) : act_ok;
   end

   assign strobe_end = (phase == PH_STROBE) && strobe_over;

   always_comb begin
      resid    = (CW'(cyc_q) > cnt) ? (CW'(cyc_q) - cnt) : '0;
      rec_need = resid;
      if (CW'(rec_q) > rec_need)            rec_need = CW'(rec_q);
      if (wr_q && (CW'(hold_q) > rec_need)) rec_need = CW'(hold_q);
      if (rec_need == '0)                   rec_need = CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         setup_q <= '0;
         act_q   <= '0;
         rec_q   <= '0;
         cyc_q   <= '0;
         hold_q  <= 2'd1;
         wr_q    <= 1'b0;
         ren_q   <= 1'b0;
         rec_len <= CW'(1);
         done    <= 1'b0;
         timeout <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  setup_q <= start_setup;
                  act_q   <= start_act;
                  rec_q   <= start_rec;
                  cyc_q   <= start_cyc;
                  hold_q  <= start_hold;
                  wr_q    <= start_write;
                  ren_q   <= start_rdy_en;
                  phase   <= PH_SETUP;
                  cnt     <= CW'(1);
               end
            end
            PH_SETUP: begin
               if (cnt >= CW'(setup_q)) begin
                  phase <= PH_STROBE;
                  cnt   <= CW'(1);
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            PH_STROBE: begin
               if (strobe_over) begin
                  phase   <= PH_RECOVER;
                  cnt     <= CW'(1);
                  rec_len <= rec_need;
                  if (ren_q && !rdy_seen) timeout <= 1'b1;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            PH_RECOVER: begin
               if (cnt >= rec_len) begin
                  phase <= PH_IDLE;
                  cnt   <= '0;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pio_bus_drive.sv
module pio_bus_drive
   import pio_pkg::*;
#(
   parameter int DW = 16,
   parameter int CW = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_write,
   input  logic [SEL_W-1:0] start_sel,
   input  logic [DW-1:0]    start_wdata,
   input  pio_phase_e       phase,
   input  logic [CW-1:0]    cnt,
   input  logic [1:0]       hold,
   input  logic             strobe_end,
   input  logic [DW-1:0]    dd_in,
   output logic             cs_cmd_n,
   output logic             cs_ctl_n,
   output logic [2:0]       addr,
   output logic             rd_n,
   output logic             wr_n,
   output logic             dd_oe,
   output logic [DW-1:0]    dd_out,
   output logic [DW-1:0]    rdata
);
   logic [SEL_W-1:0] sel_q;
   logic             wr_q;
   logic [DW-1:0]    wdata_q;
   logic             busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '1;
         wr_q    <= 1'b0;
         wdata_q <= '0;
         rdata   <= '0;
      end else begin
         if (start) begin
            sel_q   <= start_sel;
            wr_q    <= start_write;
            wdata_q <= start_wdata;
         end
         if (strobe_end && !wr_q) rdata <= dd_in;
      end
   end

   assign busy     = (phase != PH_IDLE);
   assign cs_cmd_n = busy ? sel_q[0] : 1'b1;
   assign cs_ctl_n = busy ? sel_q[1] : 1'b1;
   assign addr     = busy ? sel_q[4:2] : 3'd0;
   assign rd_n     = !((phase == PH_STROBE) && !wr_q);
   assign wr_n     = !((phase == PH_STROBE) && wr_q);
   assign dd_oe    = wr_q && ((phase == PH_STROBE) ||
                              ((phase == PH_RECOVER) && (cnt <= CW'(hold))));
   assign dd_out   = wdata_q;
endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
   import pio_pkg::*;
#(
   parameter int DW         = 16,
   parameter int TW         = 8,
   parameter int RDY_SAMPLE = 7,
   parameter int RDY_CAP    = 257,
   parameter int RDY_SYNC   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic          req_wide,
   input  logic [4:0]    req_sel,
   input  logic [DW-1:0] req_wdata,
   input  logic          cfg_rdy_en,
   input  logic [2:0]    cfg_pio_mode,
   input  logic [TW-1:0] t_setup,
   input  logic [TW-1:0] t_act_reg,
   input  logic [TW-1:0] t_rec_reg,
   input  logic [TW-1:0] t_cyc_reg,
   input  logic [TW-1:0] t_act_dat,
   input  logic [TW-1:0] t_rec_dat,
   input  logic [TW-1:0] t_cyc_dat,
   output logic          ata_cs_cmd_n,
   output logic          ata_cs_ctl_n,
   output logic [2:0]    ata_addr,
   output logic          ata_rd_n,
   output logic          ata_wr_n,
   output logic          ata_dd_oe,
   output logic [DW-1:0] ata_dd_out,
   input  logic [DW-1:0] ata_dd_in,
   input  logic          ata_rdy,
   output logic          done,
   output logic [DW-1:0] rdata,
   output logic          rdy_timeout
);
   localparam int CAP_W = $clog2(RDY_CAP + 1);
   localparam int CW    = ((CAP_W > TW) ? CAP_W : TW) + 1;

   generate
      if (RDY_CAP <= RDY_SAMPLE) begin : g_bad_cap
         $error("RDY_CAP must exceed RDY_SAMPLE");
      end
      if (RDY_SYNC < 0 || RDY_SYNC > 3) begin : g_bad_sync
         $error("RDY_SYNC must be 0..3");
      end
      if (TW < 2 || DW < 8) begin : g_bad_width
         $error("TW or DW too small");
      end
   endgenerate

   pio_phase_e    phase;
   logic [CW-1:0] cnt;
   logic [1:0]    hold_q;
   logic          strobe_end;
   logic          rdy_s;
   logic          start;
   logic [TW-1:0] sel_act, sel_rec, sel_cyc;

   assign req_ready = (phase == PH_IDLE);
   assign start     = req_valid && req_ready;
   assign sel_act   = req_wide ? t_act_dat : t_act_reg;
   assign sel_rec   = req_wide ? t_rec_dat : t_rec_reg;
   assign sel_cyc   = req_wide ? t_cyc_dat : t_cyc_reg;

   pio_rdy_sync #(.STAGES(RDY_SYNC)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .rdy_in  (ata_rdy),
      .rdy_out (rdy_s)
   );

   pio_phase_fsm #(
      .TW(TW), .RDY_SAMPLE(RDY_SAMPLE), .RDY_CAP(RDY_CAP), .CW(CW)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_write  (req_write),
      .start_rdy_en (cfg_rdy_en),
      .start_hold   (hold_clocks(cfg_pio_mode)),
      .start_setup  (t_setup),
      .start_act    (sel_act),
      .start_rec    (sel_rec),
      .start_cyc    (sel_cyc),
      .rdy_s        (rdy_s),
      .phase        (phase),
      .cnt          (cnt),
      .hold_q       (hold_q),
      .strobe_end   (strobe_end),
      .done         (done),
      .timeout      (rdy_timeout)
   );

   pio_bus_drive #(.DW(DW), .CW(CW)) u_bus (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_write (req_write),
      .start_sel   (req_sel),
      .start_wdata (req_wdata),
      .phase       (phase),
      .cnt         (cnt),
      .hold        (hold_q),
      .strobe_end  (strobe_end),
      .dd_in       (ata_dd_in),
      .cs_cmd_n    (ata_cs_cmd_n),
      .cs_ctl_n    (ata_cs_ctl_n),
      .addr        (ata_addr),
      .rd_n        (ata_rd_n),
      .wr_n        (ata_wr_n),
      .dd_oe       (ata_dd_oe),
      .dd_out      (ata_dd_out),
      .rdata       (rdata)
   );
endmodule

// File: rtl/pio_cycle_engine_chk.sv
module pio_cycle_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic       done,
   input logic       ata_rd_n,
   input logic       ata_wr_n,
   input logic       ata_dd_oe,
   input logic       ata_cs_cmd_n,
   input logic       ata_cs_ctl_n,
   input logic [2:0] ata_addr,
   input logic       rdy_timeout
);
   // R4: never both strobes at once
   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ata_rd_n && !ata_wr_n));

   // R11: strobes only while busy
   a_r11_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!ata_rd_n || !ata_wr_n) |-> !req_ready);

   // R11: done is a single clock and comes with ready
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r11_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   // R10: bus is never driven during a read strobe
   a_r10_no_oe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !ata_rd_n |-> !ata_dd_oe);

   // R2: idle means deselected; address holds through a cycle
   a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ata_cs_cmd_n && ata_cs_ctl_n));
   a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !$past(req_ready)) |-> $stable(ata_addr));

   // R7: timeout flag is sticky
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_timeout |=> rdy_timeout);
endmodule

bind pio_cycle_engine pio_cycle_engine_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .done         (done),
   .ata_rd_n     (ata_rd_n),
   .ata_wr_n     (ata_wr_n),
   .ata_dd_oe    (ata_dd_oe),
   .ata_cs_cmd_n (ata_cs_cmd_n),
   .ata_cs_ctl_n (ata_cs_ctl_n),
   .ata_addr     (ata_addr),
   .rdy_timeout  (rdy_timeout)
);

// File: tb/sim_pio_cycle_engine.sv
`timescale 1ns/1ps
module sim_pio_cycle_engine;
   localparam int DW = 16, TW = 8, SAMPLE = 7, CAP = 257, SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          req_valid = 0, req_write = 0, req_wide = 0;
   logic [4:0]    req_sel = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          cfg_rdy_en = 0;
   logic [2:0]    cfg_pio_mode = 3'd4;
   logic [TW-1:0] t_setup = 0, t_act_reg = 0, t_rec_reg = 0, t_cyc_reg = 0;
   logic [TW-1:0] t_act_dat = 0, t_rec_dat = 0, t_cyc_dat = 0;
   logic [DW-1:0] ata_dd_in = '0;
   logic          ata_rdy = 1'b1;
   logic          req_ready, ata_cs_cmd_n, ata_cs_ctl_n, ata_rd_n, ata_wr_n, ata_dd_oe;
   logic [2:0]    ata_addr;
   logic [DW-1:0] ata_dd_out, rdata;
   logic          done, rdy_timeout;

   pio_cycle_engine #(.DW(DW), .TW(TW), .RDY_SAMPLE(SAMPLE), .RDY_CAP(CAP), .RDY_SYNC(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_wide(req_wide), .req_sel(req_sel), .req_wdata(req_wdata),
      .cfg_rdy_en(cfg_rdy_en), .cfg_pio_mode(cfg_pio_mode), .t_setup(t_setup),
      .t_act_reg(t_act_reg), .t_rec_reg(t_rec_reg), .t_cyc_reg(t_cyc_reg),
      .t_act_dat(t_act_dat), .t_rec_dat(t_rec_dat), .t_cyc_dat(t_cyc_dat),
      .ata_cs_cmd_n(ata_cs_cmd_n), .ata_cs_ctl_n(ata_cs_ctl_n), .ata_addr(ata_addr),
      .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_dd_oe(ata_dd_oe), .ata_dd_out(ata_dd_out),
      .ata_dd_in(ata_dd_in), .ata_rdy(ata_rdy), .done(done), .rdata(rdata),
      .rdy_timeout(rdy_timeout));

   typedef struct {
      bit          wr;
      logic [4:0]  sel;
      logic [15:0] wd;
      logic [15:0] rd;
      int          n_setup, n_low, n_rec, n_hold, raise_at;
   } exp_t;
   exp_t exp_q[$];

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // driver: computes expectation from the requirements and runs one request
   task automatic run(input bit wr, input bit wide, input logic [4:0] sel,
                      input logic [15:0] wd, input logic [15:0] rd,
                      input int plan, input int m);
      exp_t e;
      int a, r, c, n, wst, res;
      a = wide ? int'(t_act_dat) : int'(t_act_reg);
      r = wide ? int'(t_rec_dat) : int'(t_rec_reg);
      c = wide ? int'(t_cyc_dat) : int'(t_cyc_reg);
      n = imax(a, 1);
      if (cfg_rdy_en) begin
         if (plan == 0)      n = imax(n, SAMPLE);
         else if (plan == 1) n = CAP;
         else                n = imax(imax(m + SYNC, a), SAMPLE);
         if (n > CAP) n = CAP;
      end
      wst = (cfg_pio_mode == 0) ? 3 : (cfg_pio_mode <= 2) ? 2 : 1;
      res = (c > n) ? c - n : 0;
      e.wr = wr; e.sel = sel; e.wd = wd; e.rd = rd;
      e.n_setup = imax(int'(t_setup), 1);
      e.n_low   = n;
      e.n_rec   = imax(imax(res, r), imax(wr ? wst : 0, 1));
      e.n_hold  = wr ? wst : 0;
      e.raise_at = (cfg_rdy_en && plan == 2) ? m : 0;
      ata_rdy   = (cfg_rdy_en && plan != 0) ? 1'b0 : 1'b1;
      ata_dd_in = rd;
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_wide = wide; req_sel = sel; req_wdata = wd;
      @(negedge clk);
      req_valid = 0; req_wdata = 16'h0000;
      while (exp_q.size() != 0) @(negedge clk);
      ata_rdy = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // monitor: measures phases at the pins and compares on done
   initial begin
      int setup_c, low_c, rec_c, hold_c;
      bit saw, after, prev_done;
      setup_c = 0; low_c = 0; rec_c = 0; hold_c = 0; saw = 0; after = 0; prev_done = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (prev_done) chk(!done, "R11 done lasts one clock", done, 0);
            prev_done = done;
            if (!ata_rd_n || !ata_wr_n) begin
               low_c++;
               saw = 1;
               if (low_c == 1 && exp_q.size() != 0) begin
                  chk(!req_ready, "R11 ready low while busy", req_ready, 0);
                  chk({ata_addr, ata_cs_ctl_n, ata_cs_cmd_n} == exp_q[0].sel,
                      "R2 select code on cable", {ata_addr, ata_cs_ctl_n, ata_cs_cmd_n}, exp_q[0].sel);
                  chk(ata_wr_n == !exp_q[0].wr && ata_rd_n == exp_q[0].wr,
                      "R4 strobe matches direction", {ata_rd_n, ata_wr_n}, {exp_q[0].wr, !exp_q[0].wr});
                  if (exp_q[0].wr)
                     chk(ata_dd_oe && ata_dd_out == exp_q[0].wd, "R10 write word driven",
                         ata_dd_out, exp_q[0].wd);
               end
               if (exp_q.size() != 0 && exp_q[0].raise_at != 0 && low_c == exp_q[0].raise_at)
                  ata_rdy = 1'b1;
            end else if (saw && !done) begin
               rec_c++;
               if (ata_dd_oe) hold_c++;
               if (!after && exp_q.size() != 0) begin
                  after = 1;
                  ata_dd_in = ~exp_q[0].rd;
               end
            end else if (!saw && (!ata_cs_cmd_n || !ata_cs_ctl_n)) begin
               setup_c++;
            end
            if (done) begin
               if (exp_q.size() == 0) begin
                  chk(0, "R11 unexpected done", 1, 0);
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  chk(req_ready, "R11 ready with done", req_ready, 1);
                  chk(setup_c == e.n_setup, "R3 setup clocks", setup_c, e.n_setup);
                  chk(low_c == e.n_low, "R4/R5/R6 strobe clocks", low_c, e.n_low);
                  chk(rec_c == e.n_rec, "R8 recovery clocks", rec_c, e.n_rec);
                  if (e.wr) chk(hold_c == e.n_hold, "R10 write hold clocks", hold_c, e.n_hold);
                  else      chk(rdata == e.rd, "R9 read capture at strobe rise", rdata, e.rd);
               end
               setup_c = 0; low_c = 0; rec_c = 0; hold_c = 0; saw = 0; after = 0;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ata_rd_n && ata_wr_n, "R1 strobes idle", {ata_rd_n, ata_wr_n}, 3);
      chk(ata_cs_cmd_n && ata_cs_ctl_n, "R1 selects idle", {ata_cs_cmd_n, ata_cs_ctl_n}, 3);
      chk(!ata_dd_oe && req_ready && !done, "R1 oe/ready/done", {ata_dd_oe, req_ready, done}, 3'b010);
      chk(!rdy_timeout, "R1 timeout clear", rdy_timeout, 0);

      // R5 distinct timing sets, ready checking off
      t_setup = 2; t_act_reg = 4; t_rec_reg = 3; t_cyc_reg = 12;
      t_act_dat = 3; t_rec_dat = 2; t_cyc_dat = 6; cfg_pio_mode = 3'd4;
      run(0, 0, 5'h1E, 16'h0, 16'h00A5, 0, 0);   // status register read
      run(1, 1, 5'h02, 16'h1234, 16'h0, 0, 0);   // data write
      run(0, 1, 5'h02, 16'h0, 16'hBEEF, 0, 0);   // data read
      run(1, 0, 5'h19, 16'h0006, 16'h0, 0, 0);   // control register write

      // R10 hold per mode, recovery driven by hold
      t_rec_reg = 1; t_cyc_reg = 0;
      cfg_pio_mode = 3'd0; run(1, 0, 5'h0A, 16'h0055, 16'h0, 0, 0);
      cfg_pio_mode = 3'd1; run(1, 0, 5'h0E, 16'h00AA, 16'h0, 0, 0);
      cfg_pio_mode = 3'd7; run(1, 0, 5'h12, 16'h0033, 16'h0, 0, 0);

      // R3/R4/R8 zero counts hit the one-clock floors
      t_setup = 0; t_act_reg = 0; t_rec_reg = 0; t_cyc_reg = 0;
      run(0, 0, 5'h06, 16'h0, 16'h5A5A, 0, 0);

      // R8 long cycle residue
      t_setup = 1; t_act_reg = 4; t_rec_reg = 2; t_cyc_reg = 40;
      run(0, 0, 5'h10, 16'h0, 16'hC3C3, 0, 0);

      // R6 ready checking: sample floor, long act, late ready
      cfg_rdy_en = 1;
      run(0, 0, 5'h1E, 16'h0, 16'h0101, 0, 0);
      t_act_reg = 10;
      run(0, 0, 5'h1E, 16'h0, 16'h0202, 0, 0);
      t_act_reg = 5;
      run(1, 1, 5'h02, 16'h7777, 16'h0, 2, 20);
      chk(!rdy_timeout, "R7 no timeout while ready answers", rdy_timeout, 0);

      // R7 stuck-low ready hits the cap and sets the sticky flag
      run(0, 1, 5'h02, 16'h0, 16'h0F0F, 1, 0);
      chk(rdy_timeout, "R7 timeout set", rdy_timeout, 1);
      run(0, 0, 5'h1E, 16'h0, 16'h0303, 0, 0);
      chk(rdy_timeout, "R7 timeout sticky", rdy_timeout, 1);

      repeat (5) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule